// File: doc/BRIEF.md
# DRAM Access Sequencer

This block runs read and write accesses to an asynchronous DRAM array from a single system clock. A request is presented as an address strobe that is qualified by a chip select. The sequencer then pulls the row strobe low and holds the row half of the request address on the DRAM address pins for a programmed hold time. Next it switches the multiplexer to the column half and pulls the column strobe low. After a programmed number of wait states it raises a one-cycle acknowledge that marks the end of the transfer.

Two operating styles are selectable. In normal mode the row strobe is released after every access. It is released once a programmed minimum low time has elapsed, and a programmed precharge interval then follows. In page mode the row stays open after the acknowledge. A later request that hits the open row needs only a column phase. A request that misses closes the row, waits out the precharge interval and then reopens at the new row. The hit decision comes either from an internal comparator or from an external hit pin. Opening, page and burst accesses each take their own wait-state count. A grant pin releases all DRAM-side pins to high impedance so that a second controller can drive the array.

The request side has no ready signal. A request is taken only in the cycles where the sequencer is idle or holding an open page, and a strobe in any other cycle is dropped. A requester therefore waits for `ack_o` before it strobes again. All configuration inputs are plain levels and are held steady while accesses are in flight.

Top module: `dram_seq`

## Requirements
- R1: A request is accepted at a rising clock edge only when `req_stb` and `req_cs` are both high and the sequencer is idle (row strobe high) or holding an open page. A strobe without chip select, or one that arrives during any other phase, has no effect on the DRAM pins.
- R2: For an opening access, `ras_n_o` goes low in the cycle that follows the accepting edge. `dram_addr_o` then carries the row field, which is the upper ROW_W bits of `req_addr`, zero-extended.
- R3: The row phase lasts max(`cfg_rah`,1) cycles with `cas_n_o` high. In the next cycle `dram_addr_o` switches to the column field (the lower COL_W bits of `req_addr`) and `cas_n_o` goes low.
- R4: `cas_n_o` stays low for W+1 cycles, where W is the selected wait count. `ack_o` is high in the last of these cycles only, and `cas_n_o` returns high after it.
- R5: The wait count W is taken as follows. It is `cfg_ws_burst` when `req_burst` is high at acceptance. Otherwise it is `cfg_ws_page` for a page hit and `cfg_ws_open` for an opening access.
- R6: In normal mode (`cfg_page_mode`=0), the row strobe stays low for max(R+W+1, `cfg_tras`) cycles in total, where R is the row phase length. It is then high for max(`cfg_prech`,1) cycles before the next request can be accepted.
- R7: In page mode, `ras_n_o` stays low with `cas_n_o` high after the acknowledge. An accepted page hit drives `cas_n_o` low in the following cycle with the new column on `dram_addr_o`, and there is no row phase.
- R8: With `cfg_ext_cmp`=0, a page hit means the request row equals the row of the most recent opening access. With `cfg_ext_cmp`=1, a page hit is `page_hit_i` sampled at acceptance.
- R9: On a page miss, `ras_n_o` is high for max(`cfg_prech`,1) cycles starting in the following cycle. An opening access for the new request then follows at once.
- R10: While `grant_i` is high, `ras_n_o`, `cas_n_o`, `we_n_o` and `dram_addr_o` are high impedance. Sequencing and `ack_o` continue unchanged.
- R11: `we_n_o` is low exactly in the column-strobe cycles of an access that had `req_wr` high at acceptance.
- R12: After reset, `ras_n_o`, `cas_n_o` and `we_n_o` are high, `ack_o` is low and `dram_addr_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_page_mode | input | 1 | 1 selects page mode, 0 selects normal mode |
| cfg_ext_cmp | input | 1 | 1 takes the hit decision from `page_hit_i` |
| cfg_rah | input | CW | Row hold cycles |
| cfg_ws_open | input | CW | Wait states for opening accesses |
| cfg_ws_page | input | CW | Wait states for page hits |
| cfg_ws_burst | input | CW | Wait states for burst accesses |
| cfg_tras | input | CW | Minimum row strobe low time in normal mode |
| cfg_prech | input | CW | Precharge cycles |
| req_stb | input | 1 | Address strobe, active high |
| req_cs | input | 1 | Chip select qualifying the strobe |
| req_wr | input | 1 | Write access when high |
| req_burst | input | 1 | Burst access when high |
| req_addr | input | ROW_W+COL_W | Request address, {row, column} |
| page_hit_i | input | 1 | External page-hit indication |
| grant_i | input | 1 | High releases DRAM pins to high impedance |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| dram_addr_o | output | max(ROW_W,COL_W) | Multiplexed DRAM address |
| ack_o | output | 1 | One-cycle transfer acknowledge |

## Verification
The assertions assume that all `cfg_*` inputs stay constant between resets. The bench meets this by changing configuration only while reset is held, and a reset starts every test section. The assertions place no limit on when strobes arrive. The stimulus therefore also sends strobes without chip select, strobes during busy phases and back-to-back strobes, and the cycle model drops these just as R1 requires. High impedance is made visible with weak pull values on the bench nets: ones on the strobes and zeros on the address.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ROW  = 3'd1,
    ST_COL  = 3'd2,
    ST_HOLD = 3'd3,
    ST_PRE  = 3'd4,
    ST_OPEN = 3'd5
  } dseq_state_e;

  function automatic logic ras_low_state(dseq_state_e s);
    return (s == ST_ROW) || (s == ST_COL) || (s == ST_HOLD) || (s == ST_OPEN);
  endfunction

endpackage

// File: rtl/dseq_timer.sv
module dseq_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic          is_zero,
  output logic          at_most_one
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (dec && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign is_zero     = (cnt_q == '0);
  assign at_most_one = (cnt_q <= CW'(1));

endmodule

// File: rtl/dseq_pagecmp.sv
module dseq_pagecmp #(
  parameter int ROW_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [ROW_W-1:0] row_in,
  input  logic             ext_sel,
  input  logic             ext_hit,
  output logic             hit
);

  logic [ROW_W-1:0] open_row_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_row_q <= '0;
    end else if (capture) begin
      open_row_q <= row_in;
    end
  end

  assign hit = ext_sel ? ext_hit : (row_in == open_row_q);

endmodule

// File: rtl/dseq_fsm.sv
module dseq_fsm
  import dseq_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_page_mode,
  input  logic [CW-1:0] cfg_rah,
  input  logic [CW-1:0] cfg_ws_open,
  input  logic [CW-1:0] cfg_ws_page,
  input  logic [CW-1:0] cfg_ws_burst,
  input  logic [CW-1:0] cfg_tras,
  input  logic [CW-1:0] cfg_prech,
  input  logic          req_stb,
  input  logic          req_cs,
  input  logic          req_wr,
  input  logic          req_burst,
  input  logic          page_hit,
  output logic          accept,
  output logic          open_capture,
  output logic          ras_n,
  output logic          cas_n,
  output logic          we_n,
  output logic          col_sel,
  output logic          ack,
  output dseq_state_e   state
);

  localparam int RCW = CW + 1;

  dseq_state_e   st_q, st_d;
  logic          wr_q;
  logic          reopen_q;
  logic [CW-1:0] ws_q;
  logic [CW-1:0] ws_sel;
  logic [RCW-1:0] ras_cnt_q;
  logic          ras_start;
  logic          ras_done;

  logic          tm_load;
  logic [CW-1:0] tm_val;
  logic          tm_dec;
  logic          tm_zero;
  logic          tm_le1;

  dseq_timer #(.CW(CW)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (tm_load),
    .load_val    (tm_val),
    .dec         (tm_dec),
    .is_zero     (tm_zero),
    .at_most_one (tm_le1)
  );

  assign accept   = req_stb && req_cs && ((st_q == ST_IDLE) || (st_q == ST_OPEN));
  assign ras_done = (ras_cnt_q >= RCW'(cfg_tras));

  always_comb begin
    if (req_burst) begin
      ws_sel = cfg_ws_burst;
    end else if ((st_q == ST_OPEN) && page_hit) begin
      ws_sel = cfg_ws_page;
    end else begin
      ws_sel = cfg_ws_open;
    end
  end

  always_comb begin
    st_d         = st_q;
    tm_load      = 1'b0;
    tm_val       = '0;
    tm_dec       = 1'b0;
    open_capture = 1'b0;
    ras_start    = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          st_d         = ST_ROW;
          tm_load      = 1'b1;
          tm_val       = cfg_rah;
          open_capture = 1'b1;
          ras_start    = 1'b1;
        end
      end
      ST_ROW: begin
        if (tm_le1) begin
          st_d    = ST_COL;
          tm_load = 1'b1;
          tm_val  = ws_q;
        end else begin
          tm_dec = 1'b1;
        end
      end
      ST_COL: begin
        if (tm_zero) begin
          if (cfg_page_mode) begin
            st_d = ST_OPEN;
          end else if (ras_done) begin
            st_d    = ST_PRE;
            tm_load = 1'b1;
            tm_val  = cfg_prech;
          end else begin
            st_d = ST_HOLD;
          end
        end else begin
          tm_dec = 1'b1;
        end
      end
      ST_HOLD: begin
        if (ras_done) begin
          st_d    = ST_PRE;
          tm_load = 1'b1;
          tm_val  = cfg_prech;
        end
      end
      ST_PRE: begin
        if (tm_le1) begin
          if (reopen_q) begin
            st_d      = ST_ROW;
            tm_load   = 1'b1;
            tm_val    = cfg_rah;
            ras_start = 1'b1;
          end else begin
            st_d = ST_IDLE;
          end
        end else begin
          tm_dec = 1'b1;
        end
      end
      ST_OPEN: begin
        if (accept) begin
          tm_load = 1'b1;
          if (page_hit) begin
            st_d   = ST_COL;
            tm_val = ws_sel;
          end else begin
            st_d         = ST_PRE;
            tm_val       = cfg_prech;
            open_capture = 1'b1;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      wr_q      <= 1'b0;
      ws_q      <= '0;
      reopen_q  <= 1'b0;
      ras_cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        wr_q <= req_wr;
        ws_q <= ws_sel;
      end
      if ((st_q == ST_OPEN) && accept && !page_hit) begin
        reopen_q <= 1'b1;
      end else if ((st_q == ST_PRE) && tm_le1) begin
        reopen_q <= 1'b0;
      end
      if (ras_start) begin
        ras_cnt_q <= RCW'(1);
      end else if (ras_low_state(st_q) && (ras_cnt_q != '1)) begin
        ras_cnt_q <= ras_cnt_q + 1'b1;
      end
    end
  end

  assign ras_n   = !ras_low_state(st_q);
  assign cas_n   = (st_q != ST_COL);
  assign we_n    = !((st_q == ST_COL) && wr_q);
  assign col_sel = (st_q == ST_COL);
  assign ack     = (st_q == ST_COL) && tm_zero;
  assign state   = st_q;

endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dseq_pkg::*;
#(
  parameter int ROW_W = 10,
  parameter int COL_W = 10,
  parameter int CW    = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_page_mode,
  input  logic                   cfg_ext_cmp,
  input  logic [CW-1:0]          cfg_rah,
  input  logic [CW-1:0]          cfg_ws_open,
  input  logic [CW-1:0]          cfg_ws_page,
  input  logic [CW-1:0]          cfg_ws_burst,
  input  logic [CW-1:0]          cfg_tras,
  input  logic [CW-1:0]          cfg_prech,
  input  logic                   req_stb,
  input  logic                   req_cs,
  input  logic                   req_wr,
  input  logic                   req_burst,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic                   page_hit_i,
  input  logic                   grant_i,
  output logic                   ras_n_o,
  output logic                   cas_n_o,
  output logic                   we_n_o,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr_o,
  output logic                   ack_o
);

  localparam int DA_W = (ROW_W > COL_W) ? ROW_W : COL_W;

  logic [ROW_W-1:0] req_row;
  logic [COL_W-1:0] req_col;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic [DA_W-1:0]  addr_int;

  logic        accept;
  logic        open_capture;
  logic        hit;
  logic        ras_int;
  logic        cas_int;
  logic        we_int;
  logic        col_sel;
  logic        ack_int;
  dseq_state_e state;

  assign req_row = req_addr[ROW_W+COL_W-1:COL_W];
  assign req_col = req_addr[COL_W-1:0];

  dseq_pagecmp #(.ROW_W(ROW_W)) u_cmp (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (open_capture),
    .row_in  (req_row),
    .ext_sel (cfg_ext_cmp),
    .ext_hit (page_hit_i),
    .hit     (hit)
  );

  dseq_fsm #(.CW(CW)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_page_mode (cfg_page_mode),
    .cfg_rah       (cfg_rah),
    .cfg_ws_open   (cfg_ws_open),
    .cfg_ws_page   (cfg_ws_page),
    .cfg_ws_burst  (cfg_ws_burst),
    .cfg_tras      (cfg_tras),
    .cfg_prech     (cfg_prech),
    .req_stb       (req_stb),
    .req_cs        (req_cs),
    .req_wr        (req_wr),
    .req_burst     (req_burst),
    .page_hit      (hit),
    .accept        (accept),
    .open_capture  (open_capture),
    .ras_n         (ras_int),
    .cas_n         (cas_int),
    .we_n          (we_int),
    .col_sel       (col_sel),
    .ack           (ack_int),
    .state         (state)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
    end else if (accept) begin
      row_q <= req_row;
      col_q <= req_col;
    end
  end

  assign addr_int = col_sel ? DA_W'(col_q) : DA_W'(row_q);

  assign ras_n_o     = grant_i ? 1'bz : ras_int;
  assign cas_n_o     = grant_i ? 1'bz : cas_int;
  assign we_n_o      = grant_i ? 1'bz : we_int;
  assign dram_addr_o = grant_i ? {DA_W{1'bz}} : addr_int;
  assign ack_o       = ack_int;

endmodule

// File: rtl/dseq_chk.sv
module dseq_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stb,
  input logic          cs,
  input logic          idle,
  input logic          ras_n,
  input logic          cas_n,
  input logic          we_n,
  input logic          ack,
  input logic [AW-1:0] addr
);

  AST_START_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && cs && idle) |=> !ras_n); // R2

  AST_ROW_BEFORE_CAS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> cas_n); // R3

  AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n); // R3

  AST_COL_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n && $past(!cas_n)) |-> $stable(addr)); // R4

  AST_ACK_IN_CAS: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> !cas_n); // R4

  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack); // R4

  AST_WE_ONLY_CAS: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !cas_n); // R11

endmodule

bind dram_seq dseq_chk #(.AW(DA_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .stb   (req_stb),
  .cs    (req_cs),
  .idle  (state == dseq_pkg::ST_IDLE),
  .ras_n (ras_int),
  .cas_n (cas_int),
  .we_n  (we_int),
  .ack   (ack_int),
  .addr  (addr_int)
);

// File: tb/sim_dram_seq.sv
`timescale 1ns/1ps
module sim_dram_seq;

  localparam int ROW_W = 10;
  localparam int COL_W = 10;
  localparam int CW    = 4;
  localparam int DA_W  = (ROW_W > COL_W) ? ROW_W : COL_W;

  typedef struct packed {
    logic            ras_n;
    logic            cas_n;
    logic            we_n;
    logic            ack;
    logic [DA_W-1:0] addr;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic c_page = 1'b0, c_ext = 1'b0;
  logic [CW-1:0] c_rah = '0, c_wso = '0, c_wsp = '0, c_wsb = '0, c_tras = '0, c_prech = '0;
  logic stb = 1'b0, cs = 1'b0, wr = 1'b0, burst = 1'b0, phit = 1'b0, grant = 1'b0;
  logic [ROW_W+COL_W-1:0] addr = '0;

  wire            ras_w;
  wire            cas_w;
  wire            we_w;
  wire [DA_W-1:0] addr_w;
  logic           ack_w;

  assign (weak0, weak1) ras_w  = 1'b1;
  assign (weak0, weak1) cas_w  = 1'b1;
  assign (weak0, weak1) we_w   = 1'b1;
  assign (weak0, weak1) addr_w = '0;

  int compared = 0;
  int mismatched = 0;
  bit running = 1'b0;

  exp_t  exp_q[$];
  string tag_q[$];
  bit               m_open = 1'b0;
  logic [ROW_W-1:0] m_row = '0;
  logic [COL_W-1:0] m_col = '0;
  logic [ROW_W-1:0] m_open_row = '0;

  always #2 clk = ~clk;

  dram_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_page_mode(c_page), .cfg_ext_cmp(c_ext), .cfg_rah(c_rah),
    .cfg_ws_open(c_wso), .cfg_ws_page(c_wsp), .cfg_ws_burst(c_wsb),
    .cfg_tras(c_tras), .cfg_prech(c_prech),
    .req_stb(stb), .req_cs(cs), .req_wr(wr), .req_burst(burst),
    .req_addr(addr), .page_hit_i(phit), .grant_i(grant),
    .ras_n_o(ras_w), .cas_n_o(cas_w), .we_n_o(we_w),
    .dram_addr_o(addr_w), .ack_o(ack_w)
  );

  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  task automatic chk(string tg, string f, logic [31:0] act, logic [31:0] ex);
    compared++;
    if (act !== ex) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tg, f, act, ex, $time);
    end
  endtask

  function automatic void push(logic r, logic c, logic w, logic a, logic [DA_W-1:0] ad, string tg);
    exp_t e;
    e.ras_n = r; e.cas_n = c; e.we_n = w; e.ack = a; e.addr = ad;
    exp_q.push_back(e);
    tag_q.push_back(tg);
  endfunction

  function automatic void push_col(int w_cnt, logic wrv, string tg_mid, string tg_ack);
    for (int i = 0; i <= w_cnt; i++)
      push(1'b0, 1'b0, ~wrv, (i == w_cnt), DA_W'(m_col), (i == w_cnt) ? tg_ack : tg_mid);
  endfunction

  // R2 R3 R4 R5 R6: opening access timeline
  function automatic void push_opening(logic wrv, logic bst);
    int rl, wc, tot;
    m_open_row = m_row;
    rl = mx(int'(c_rah), 1);
    wc = bst ? int'(c_wsb) : int'(c_wso);
    for (int i = 0; i < rl; i++)
      push(1'b0, 1'b1, 1'b1, 1'b0, DA_W'(m_row), (i == 0) ? "R2" : "R3");
    push_col(wc, wrv, "R4", "R5");
    if (c_page) begin
      m_open = 1'b1;
    end else begin
      tot = rl + wc + 1;
      for (int i = tot; i < int'(c_tras); i++)
        push(1'b0, 1'b1, 1'b1, 1'b0, DA_W'(m_row), "R6");
      for (int i = 0; i < mx(int'(c_prech), 1); i++)
        push(1'b1, 1'b1, 1'b1, 1'b0, DA_W'(m_row), "R6");
    end
  endfunction

  function automatic void model_accept();
    logic [ROW_W-1:0] r;
    logic hit;
    r = addr[ROW_W+COL_W-1:COL_W];
    hit = c_ext ? phit : (r == m_open_row); // R8
    m_row = r;
    m_col = addr[COL_W-1:0];
    if (m_open && c_page) begin
      if (hit) begin
        push_col(burst ? int'(c_wsb) : int'(c_wsp), wr, "R7", "R8");
      end else begin
        for (int i = 0; i < mx(int'(c_prech), 1); i++)
          push(1'b1, 1'b1, 1'b1, 1'b0, DA_W'(m_row), "R9");
        push_opening(wr, burst);
      end
    end else begin
      push_opening(wr, burst);
    end
  endfunction

  always @(negedge clk) begin
    if (running) begin
      exp_t  e;
      string tg;
      bit    was_empty;
      was_empty = (exp_q.size() == 0);
      if (!was_empty) begin
        e  = exp_q.pop_front();
        tg = tag_q.pop_front();
      end else begin
        e.ras_n = ~m_open; e.cas_n = 1'b1; e.we_n = 1'b1; e.ack = 1'b0;
        e.addr = DA_W'(m_row);
        tg = "R1";
      end
      chk(tg, "ack", 32'(ack_w), 32'(e.ack));
      chk("R11", "we_n", 32'(we_w), grant ? 32'd1 : 32'(e.we_n));
      if (grant) begin
        e.ras_n = 1'b1; e.cas_n = 1'b1; e.addr = '0;
        tg = "R10";
      end
      chk(tg, "ras_n", 32'(ras_w), 32'(e.ras_n));
      chk(tg, "cas_n", 32'(cas_w), 32'(e.cas_n));
      chk(tg, "addr", 32'(addr_w), 32'(e.addr));
      if (was_empty && stb && cs) model_accept();
    end
  end

  task automatic do_reset(bit pg, bit ex, int rah, int wso, int wsp, int wsb, int tras, int pre);
    @(posedge clk); #1;
    running = 1'b0;
    rst_n = 1'b0;
    stb = 1'b0; grant = 1'b0;
    exp_q.delete(); tag_q.delete();
    m_open = 1'b0; m_row = '0; m_col = '0; m_open_row = '0;
    c_page = pg; c_ext = ex;
    c_rah = CW'(rah); c_wso = CW'(wso); c_wsp = CW'(wsp); c_wsb = CW'(wsb);
    c_tras = CW'(tras); c_prech = CW'(pre);
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R12: pins during reset
    chk("R12", "ras_n", 32'(ras_w), 32'd1);
    chk("R12", "cas_n", 32'(cas_w), 32'd1);
    chk("R12", "we_n", 32'(we_w), 32'd1);
    chk("R12", "ack", 32'(ack_w), 32'd0);
    chk("R12", "addr", 32'(addr_w), 32'd0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    running = 1'b1;
  endtask

  task automatic acc(int row, int col, bit w, bit b, bit h, bit c, int gap);
    @(posedge clk); #1;
    stb = 1'b1; cs = c; wr = w; burst = b; phit = h;
    addr = {ROW_W'(row), COL_W'(col)};
    @(posedge clk); #1;
    stb = 1'b0; cs = 1'b0;
    repeat (gap) @(posedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    // normal mode, R1 R2 R3 R4 R5 R6 R11
    do_reset(0, 0, 2, 3, 1, 5, 8, 2);
    acc(12, 34, 0, 0, 0, 1, 20);
    acc(700, 5, 1, 0, 0, 1, 20);
    acc(3, 3, 0, 0, 0, 0, 5);          // R1 no chip select
    acc(44, 9, 1, 0, 0, 1, 1);
    acc(55, 8, 0, 0, 0, 1, 25);        // R1 busy strobe dropped
    acc(66, 77, 0, 1, 0, 1, 25);       // R5 burst count
    // short timings, R3 R6 boundaries
    do_reset(0, 0, 0, 0, 2, 1, 1, 0);
    for (int i = 0; i < 12; i++) acc(i * 7, i * 11, i[0], i[1], 0, 1, i % 4);
    // page mode, internal compare, R7 R8 R9
    do_reset(1, 0, 1, 2, 1, 3, 0, 3);
    acc(5, 1, 0, 0, 0, 1, 8);
    acc(5, 2, 1, 0, 0, 1, 4);
    acc(5, 3, 0, 1, 0, 1, 6);
    acc(9, 4, 0, 0, 0, 1, 15);
    acc(9, 7, 1, 0, 0, 1, 0);
    acc(9, 8, 0, 0, 0, 1, 0);
    acc(9, 9, 0, 0, 0, 0, 6);          // R1 no chip select while open
    // page mode, external compare, R8
    do_reset(1, 1, 2, 1, 0, 2, 0, 1);
    acc(20, 1, 0, 0, 0, 1, 10);
    acc(21, 2, 0, 0, 1, 1, 6);
    acc(21, 3, 1, 0, 0, 1, 15);
    // grant, R10
    do_reset(0, 0, 2, 2, 0, 0, 6, 2);
    grant = 1'b1;
    acc(30, 31, 1, 0, 0, 1, 3);
    grant = 1'b0;
    repeat (20) @(posedge clk);
    // mixed sections
    for (int s = 0; s < 8; s++) begin
      do_reset(s[0], s[1], $urandom_range(0, 4), $urandom_range(0, 5), $urandom_range(0, 3),
               $urandom_range(0, 6), $urandom_range(0, 15), $urandom_range(0, 4));
      for (int k = 0; k < 60; k++) begin
        grant = ($urandom_range(0, 9) == 0);
        acc($urandom_range(0, 3), $urandom_range(0, 1023), $urandom_range(0, 1),
            $urandom_range(0, 1), $urandom_range(0, 1), ($urandom_range(0, 7) != 0),
            $urandom_range(0, 12));
      end
      grant = 1'b0;
      repeat (40) @(posedge clk);
    end
    running = 1'b0;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule